// File: doc/BRIEF.md
# Paged Register Window Controller

This block is an 8-bit register file that lets a small address window reach a much larger store. An 8-bit address selects one register. The sixteen highest addresses (F0h to FFh) form a window, and the window shows one of 64 banks of sixteen registers each. The bank is chosen by a page pointer that is itself a register in the same address space, at address EAh. Every other address reaches a plain, unbanked register.

Software loads the page pointer once and may then make any number of accesses through the window to that bank. It loads the pointer again only when it needs another bank. Writes take effect on the rising clock edge. Reads are combinational from the register or bank that the address currently selects.

Top module: `banked_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, every unbanked register (addresses 00h to EFh other than EAh) is cleared. After reset, each of them reads 00h.
- R2: A write (`we`=1) to an unbanked address stores `wdata` at the rising edge. From then on, a read of that address returns the stored value.
- R3: A write to address EAh loads the page number from `wdata[7:2]`, with bit 7 as the most significant page bit. A read of EAh returns the page number in bits 7:2 and zero in bits 1:0, whatever was written to bits 1:0.
- R4: An access to address F0h+k (k = 0..15) reaches register k of the bank that the page pointer selects. Banks are independent: a write in one bank leaves the same offset in every other bank unchanged.
- R5: The page pointer keeps its value until address EAh is written again, so any number of window accesses go to the same bank without reloading it.
- R6: During a write cycle, `rdata` still shows the value held before the write. The new value appears only after the rising edge.
- R7: A page pointer write takes effect from the very next cycle: a window access in the cycle right after the pointer write reaches the new bank.
- R8: With `we`=0, no register, bank entry or page pointer changes, whatever `addr` and `wdata` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| we | input | 1 | Write enable |
| rdata | output | 8 | Combinational read data for `addr` |

## Verification
The block has one address port, so a bank change and a window access can never share a cycle. The case that matters is a pointer write followed at once by a window access: the pointer update and the new bank selection then meet at the same clock edge. The bench provokes this with directed back-to-back sequences and with random streams that interleave pointer writes and window accesses. Each read is compared, just before the edge, with a bench model that applies the pointer write only after that edge. The bench also checks every write cycle for the value held before the write, so that a store which updates early is reported.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [1:0] {
        RGN_FLAT  = 2'd0,
        RGN_PTR   = 2'd1,
        RGN_PAGED = 2'd2
    } region_e;

endpackage

// File: rtl/pgw_decoder.sv
module pgw_decoder
    import pgw_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WIN_W  = 4,
    parameter logic [ADDR_W-1:0] PTR_ADDR = 8'hEA
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);

    localparam int TAG_W = ADDR_W - WIN_W;

    logic in_window;

    assign in_window = (addr[ADDR_W-1:WIN_W] == {TAG_W{1'b1}});

    always_comb begin
        if (in_window)             region = RGN_PAGED;
        else if (addr == PTR_ADDR) region = RGN_PTR;
        else                       region = RGN_FLAT;
    end

endmodule

// File: rtl/pgw_pointer.sv
module pgw_pointer #(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [PAGE_W-1:0] wr_page,
    output logic [PAGE_W-1:0] page,
    output logic [DATA_W-1:0] ptr_rd
);

    localparam int LOW_W = DATA_W - PAGE_W;

    always_ff @(posedge clk) begin
        if (rst)     page <= '0;
        else if (wr) page <= wr_page;
    end

    generate
        if (LOW_W > 0) begin : g_pad
            assign ptr_rd = {page, {LOW_W{1'b0}}};
        end else begin : g_nopad
            assign ptr_rd = page;
        end
    endgenerate

endmodule

// File: rtl/pgw_paged_store.sv
module pgw_paged_store #(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 6,
    parameter int WIN_W  = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PAGE_W-1:0] page,
    input  logic [WIN_W-1:0]  offset,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int IDX_W = PAGE_W + WIN_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  idx;

    assign idx   = {page, offset};
    assign rdata = mem[idx];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

endmodule

// File: rtl/pgw_flat_store.sv
module pgw_flat_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 240
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] regs [DEPTH];

    assign rdata = (int'(addr) < DEPTH) ? regs[addr] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (we && int'(addr) < DEPTH) begin
            regs[addr] <= wdata;
        end
    end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import pgw_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 6,
    parameter int WIN_W  = 4,
    parameter logic [ADDR_W-1:0] PTR_ADDR = 8'hEA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    output logic [DATA_W-1:0] rdata
);

    localparam int FLAT_DEPTH = (1 << ADDR_W) - (1 << WIN_W);
    localparam int LOW_W      = DATA_W - PAGE_W;

    region_e           region;
    logic [PAGE_W-1:0] page;
    logic [DATA_W-1:0] ptr_rd, flat_rd, paged_rd;
    logic              we_ptr, we_flat, we_paged;

    pgw_decoder #(
        .ADDR_W(ADDR_W), .WIN_W(WIN_W), .PTR_ADDR(PTR_ADDR)
    ) u_dec (
        .addr(addr), .region(region)
    );

    always_comb begin
        we_ptr   = 1'b0;
        we_flat  = 1'b0;
        we_paged = 1'b0;
        rdata    = '0;
        unique case (region)
            RGN_PTR: begin
                we_ptr = we;
                rdata  = ptr_rd;
            end
            RGN_PAGED: begin
                we_paged = we;
                rdata    = paged_rd;
            end
            default: begin
                we_flat = we;
                rdata   = flat_rd;
            end
        endcase
    end

    pgw_pointer #(
        .DATA_W(DATA_W), .PAGE_W(PAGE_W)
    ) u_ptr (
        .clk(clk), .rst(rst), .wr(we_ptr),
        .wr_page(wdata[DATA_W-1:LOW_W]),
        .page(page), .ptr_rd(ptr_rd)
    );

    pgw_paged_store #(
        .DATA_W(DATA_W), .PAGE_W(PAGE_W), .WIN_W(WIN_W)
    ) u_paged (
        .clk(clk), .we(we_paged), .page(page),
        .offset(addr[WIN_W-1:0]), .wdata(wdata), .rdata(paged_rd)
    );

    pgw_flat_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(FLAT_DEPTH)
    ) u_flat (
        .clk(clk), .rst(rst), .we(we_flat), .addr(addr),
        .wdata(wdata), .rdata(flat_rd)
    );

endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 6,
    parameter int WIN_W  = 4,
    parameter logic [ADDR_W-1:0] PTR_ADDR = 8'hEA
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              we,
    input logic [DATA_W-1:0] rdata
);

    localparam int LOW_W = DATA_W - PAGE_W;

    logic is_win, is_ptr, is_flat;
    assign is_win  = &addr[ADDR_W-1:WIN_W];
    assign is_ptr  = (addr == PTR_ADDR);
    assign is_flat = !is_win && !is_ptr;

    // R3: pointer low bits never read as one
    a_r3_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
        is_ptr |-> (rdata[LOW_W-1:0] == '0));

    // R3, R5: pointer holds the written page
    a_r3_ptr_load: assert property (@(posedge clk) disable iff (rst)
        (we && is_ptr) |=> (!is_ptr || rdata[DATA_W-1:LOW_W] == $past(wdata[DATA_W-1:LOW_W])));

    // R2: flat write visible on the next cycle
    a_r2_flat_write: assert property (@(posedge clk) disable iff (rst)
        (we && is_flat) |=> (!$stable(addr) || rdata == $past(wdata)));

    // R4: window write visible on the next cycle in the same bank
    a_r4_paged_write: assert property (@(posedge clk) disable iff (rst)
        (we && is_win) |=> (!$stable(addr) || rdata == $past(wdata)));

    // R8: nothing changes without a write
    a_r8_no_write_hold: assert property (@(posedge clk) disable iff (rst)
        !we |=> (!$stable(addr) || $stable(rdata)));

endmodule

bind banked_regfile pgw_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W),
    .WIN_W(WIN_W), .PTR_ADDR(PTR_ADDR)
) u_pgw_checker (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we), .rdata(rdata)
);

// File: tb/test_banked_regfile.sv
module test_banked_regfile;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       we = 1'b0;
    logic [7:0] rdata;

    always #10 clk = ~clk;

    banked_regfile i_banked_regfile (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we), .rdata(rdata)
    );

    int checks = 0;
    int errors = 0;

    logic [7:0] m_flat [256];
    logic [7:0] m_pg   [1024];
    bit         m_vld  [1024];
    logic [5:0] m_ptr = '0;
    bit         ptr_known = 1'b0;

    function automatic bit is_win(input logic [7:0] a);
        return a[7:4] == 4'hF;
    endfunction

    function automatic logic [7:0] model_rd(input logic [7:0] a);
        if (a == 8'hEA) return {m_ptr, 2'b00};
        if (is_win(a))  return m_pg[{m_ptr, a[3:0]}];
        return m_flat[a];
    endfunction

    function automatic bit model_known(input logic [7:0] a);
        if (a == 8'hEA) return ptr_known;
        if (is_win(a))  return ptr_known && m_vld[{m_ptr, a[3:0]}];
        return 1'b1;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr %02h actual %02h expected %02h", req, addr, act, exp);
        end
    endtask

    // one access: drive at negedge, check the combinational read before the edge
    task automatic step(input logic [7:0] a, input logic [7:0] d, input bit w, input string req);
        @(negedge clk);
        addr = a; wdata = d; we = w;
        #3;
        if (model_known(a)) chk(req, rdata, model_rd(a));
        @(posedge clk);
        if (w) begin
            if (a == 8'hEA) begin
                m_ptr = d[7:2];
                ptr_known = 1'b1;
            end else if (is_win(a)) begin
                m_pg[{m_ptr, a[3:0]}] = d;
                m_vld[{m_ptr, a[3:0]}] = 1'b1;
            end else begin
                m_flat[a] = d;
            end
        end
    endtask

    initial begin
        #(20 * 100000);
        checks++; errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 256; i++)  m_flat[i] = '0;
        for (int i = 0; i < 1024; i++) begin m_pg[i] = '0; m_vld[i] = 1'b0; end

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: unbanked registers read zero after reset
        for (int a = 0; a < 240; a++)
            if (a != 8'hEA) step(8'(a), 8'hFF, 1'b0, "R1");

        // R3: low pointer bits read zero after writing ones
        step(8'hEA, 8'hFF, 1'b1, "R3");
        step(8'hEA, 8'h00, 1'b0, "R3");
        step(8'hEA, 8'h17, 1'b1, "R3");
        step(8'hEA, 8'h00, 1'b0, "R3");

        // R4: same offset in banks 5 and 6 is independent; R7 back to back
        step(8'hEA, 8'd5 << 2, 1'b1, "R7");
        step(8'hF2, 8'h44, 1'b1, "R7");
        step(8'hEA, 8'd6 << 2, 1'b1, "R4");
        step(8'hF2, 8'h55, 1'b1, "R7");
        step(8'hEA, 8'd5 << 2, 1'b1, "R4");
        step(8'hF2, 8'h00, 1'b0, "R4");
        step(8'hEA, 8'd6 << 2, 1'b1, "R4");
        step(8'hF2, 8'h00, 1'b0, "R4");

        // R5: fill bank 63 then read back without reloading the pointer
        step(8'hEA, 8'hFC, 1'b1, "R5");
        for (int k = 0; k < 16; k++) step(8'hF0 + 8'(k), 8'(8'hA0 + k), 1'b1, "R5");
        for (int k = 0; k < 16; k++) step(8'hF0 + 8'(k), 8'h00, 1'b0, "R5");

        // R6: write cycle still shows the old value, new value after the edge
        step(8'h10, 8'hAA, 1'b1, "R6");
        step(8'h10, 8'h3C, 1'b1, "R6");
        step(8'h10, 8'h00, 1'b0, "R6");

        // R8: no write enable leaves state untouched
        step(8'h10, 8'h99, 1'b0, "R8");
        step(8'hEA, 8'h00, 1'b0, "R8");
        step(8'hF5, 8'h77, 1'b0, "R8");
        step(8'h10, 8'h00, 1'b0, "R8");
        step(8'hEA, 8'h00, 1'b0, "R8");

        // random mix of pointer loads, window and unbanked accesses (R2, R4, R7)
        for (int n = 0; n < 5000; n++) begin
            int unsigned sel = $urandom % 8;
            logic [7:0]  a;
            string       req;
            if (sel < 2) begin
                a = 8'hEA; req = "R3";
            end else if (sel < 5) begin
                a = 8'hF0 | 8'($urandom % 16); req = "R4";
            end else begin
                a = 8'($urandom % 240);
                if (a == 8'hEA) a = 8'h11;
                req = "R2";
            end
            step(a, 8'($urandom), bit'($urandom % 2), req);
        end

        @(negedge clk); we = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule